// File: doc/BRIEF.md
# Zero-Anchored Register Bank with Swap and Block Move

This block holds the 64-bit general registers of a processor core: 256 entries selected by an 8-bit index, of which entry 0 is fixed at zero. Two read ports are combinational and serve operand fetch. One write port updates a register at the next clock edge. Two extra commands act on the bank directly. A swap exchanges two registers in one edge. A block move copies a run of consecutive registers to another start index, one register per cycle.

Entry 0 shapes both commands. A swap that names entry 0 once clears the other register, and a swap that names it twice changes nothing. During a block move, entry 0 can be a source, where it supplies zero, but it is never written as a destination. Indices wrap modulo 256. The block moves registers in descending order when the destination lies a short way ahead of the source, and in ascending order otherwise, so overlapping runs copy correctly. While a block move is running, the `busy` output is high and the block ignores every command. The read ports keep working during that time.

Top module: `regbank_xfer`

## Requirements
- R1: After a synchronous reset, every register reads as zero and `busy` is low.
- R2: Each read port returns the present contents of the indexed register combinationally, and index 0 always reads zero.
- R3: With `wr_en` high, `wr_data` is stored in register `wr_idx` at the next rising edge, and a write to index 0 is discarded.
- R4: A swap of two nonzero indices exchanges their contents at one edge; a swap of a nonzero index with itself leaves it unchanged.
- R5: A swap with exactly one index equal to 0 clears the other register; a swap with both indices 0 changes nothing.
- R6: On one cycle the priority is swap, then block move, then write; a command that loses is discarded entirely.
- R7: A block move with count N from 1 to 255 raises `busy` on the edge after it is accepted and keeps it high for exactly N cycles.
- R8: For N up to 128, a block move leaves destination registers dst+k (k = 0..N-1, modulo 256) holding the values that source registers src+k held when the command was accepted, including overlapping runs in either direction and runs that wrap past 255.
- R9: In a block move, register 0 as a source supplies zero, and register 0 as a destination is skipped.
- R10: A block move with count 0 is accepted, leaves `busy` low and changes no register.
- R11: While `busy` is high, swap, block move and write requests are ignored, and both read ports still return current contents.
- R12: A block move runs in descending index order when (dst - src) modulo 256 is nonzero and below N, and in ascending order otherwise. One register is written per busy cycle, so the order is visible through the read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 8 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 8 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_idx | input | 8 | Write index |
| wr_data | input | 64 | Write data |
| swap_req | input | 1 | Swap request |
| swap_x | input | 8 | First swap index |
| swap_y | input | 8 | Second swap index |
| copy_req | input | 1 | Block move request |
| copy_src | input | 8 | First source index |
| copy_dst | input | 8 | First destination index |
| copy_cnt | input | 8 | Number of registers to move |
| busy | output | 1 | Block move in progress |

## Verification
The hardest state to reach is a partly finished overlapping block move. Within it, some destinations already hold new values and some sources have not yet been read. Worse still is a move that wraps past index 255 or crosses register 0. The stimulus first fills the bank with distinct values. It then starts moves whose runs overlap upward, overlap downward, wrap around the top of the index space, and include register 0 as source or destination. On every busy cycle it moves the read ports to fresh indices, so the write order itself is compared against the model. Commands are also pulsed in the middle of a move, to show that they are discarded.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_COPY  = 3'd3,
    OP_MOVE  = 3'd4
  } op_e;

  localparam int unsigned RD_PORTS = 4;
  localparam int unsigned PORT_A   = 0;
  localparam int unsigned PORT_B   = 1;
  localparam int unsigned PORT_P   = 2;
  localparam int unsigned PORT_Q   = 3;

endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned NUM_RD   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
  input  logic                           wa_en,
  input  logic [IDX_W-1:0]               wa_idx,
  input  logic [DATA_W-1:0]              wa_data,
  input  logic                           wb_en,
  input  logic [IDX_W-1:0]               wb_idx,
  input  logic [DATA_W-1:0]              wb_data
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Two write ports; index 0 is never stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else begin
      if (wa_en && (wa_idx != '0)) begin
        mem[wa_idx] <= wa_data;
      end
      if (wb_en && (wb_idx != '0)) begin
        mem[wb_idx] <= wb_data;
      end
    end
  end

  // Combinational read ports with the zero entry forced.
  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data[g] = (rd_idx[g] == '0) ? '0 : mem[rd_idx[g]];
  end

  // R4
  port_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en && (wa_idx == wb_idx)) |-> (wa_data == wb_data));

endmodule

// File: rtl/regbank_copy_seq.sv
module regbank_copy_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic [IDX_W-1:0] cnt,
  output logic             busy,
  output logic [IDX_W-1:0] mv_src,
  output logic [IDX_W-1:0] mv_dst
);

  logic [IDX_W-1:0] remaining;
  logic             desc;
  logic [IDX_W-1:0] gap;
  logic             go_down;
  logic [IDX_W-1:0] last_off;
  logic [IDX_W-1:0] first_src;
  logic [IDX_W-1:0] first_dst;

  always_comb begin
    gap       = dst - src;
    go_down   = (gap != '0) && (gap < cnt);
    last_off  = cnt - 1'b1;
    first_src = go_down ? (src + last_off) : src;
    first_dst = go_down ? (dst + last_off) : dst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      remaining <= '0;
      desc      <= 1'b0;
      mv_src    <= '0;
      mv_dst    <= '0;
    end else if (busy) begin
      mv_src    <= desc ? (mv_src - 1'b1) : (mv_src + 1'b1);
      mv_dst    <= desc ? (mv_dst - 1'b1) : (mv_dst + 1'b1);
      remaining <= remaining - 1'b1;
      if (remaining == {{(IDX_W-1){1'b0}}, 1'b1}) begin
        busy <= 1'b0;
      end
    end else if (start && (cnt != '0)) begin
      busy      <= 1'b1;
      remaining <= cnt;
      desc      <= go_down;
      mv_src    <= first_src;
      mv_dst    <= first_dst;
    end
  end

  // R10
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start && (cnt != '0)));

  // R7
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || (remaining == $past(remaining) - 1'b1)));

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

endmodule

// File: rtl/regbank_cmd_arb.sv
module regbank_cmd_arb
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              busy,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              swap_req,
  input  logic [IDX_W-1:0]  swap_x,
  input  logic [IDX_W-1:0]  swap_y,
  input  logic              copy_req,
  input  logic [IDX_W-1:0]  mv_src,
  input  logic [IDX_W-1:0]  mv_dst,
  input  logic [DATA_W-1:0] data_p,
  input  logic [DATA_W-1:0] data_q,
  output op_e               op,
  output logic [IDX_W-1:0]  rd_p_idx,
  output logic [IDX_W-1:0]  rd_q_idx,
  output logic              copy_start,
  output logic              wa_en,
  output logic [IDX_W-1:0]  wa_idx,
  output logic [DATA_W-1:0] wa_data,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  // Priority: running move, swap, block move start, plain write.
  always_comb begin
    if (busy)          op = OP_MOVE;
    else if (swap_req) op = OP_SWAP;
    else if (copy_req) op = OP_COPY;
    else if (wr_en)    op = OP_WRITE;
    else               op = OP_IDLE;
  end

  assign rd_p_idx   = busy ? mv_src : swap_x;
  assign rd_q_idx   = swap_y;
  assign copy_start = (op == OP_COPY);

  always_comb begin
    wa_en   = 1'b0;
    wa_idx  = '0;
    wa_data = '0;
    wb_en   = 1'b0;
    wb_idx  = '0;
    wb_data = '0;
    unique case (op)
      OP_MOVE: begin
        wa_en   = 1'b1;
        wa_idx  = mv_dst;
        wa_data = data_p;
      end
      OP_SWAP: begin
        wa_en   = 1'b1;
        wa_idx  = swap_x;
        wa_data = data_q;
        wb_en   = 1'b1;
        wb_idx  = swap_y;
        wb_data = data_p;
      end
      OP_WRITE: begin
        wa_en   = 1'b1;
        wa_idx  = wr_idx;
        wa_data = wr_data;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/regbank_xfer.sv
module regbank_xfer
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              swap_req,
  input  logic [IDX_W-1:0]  swap_x,
  input  logic [IDX_W-1:0]  swap_y,
  input  logic              copy_req,
  input  logic [IDX_W-1:0]  copy_src,
  input  logic [IDX_W-1:0]  copy_dst,
  input  logic [IDX_W-1:0]  copy_cnt,
  output logic              busy
);

  logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
  logic [RD_PORTS-1:0][DATA_W-1:0] rd_data;

  op_e               op;
  logic              copy_start;
  logic [IDX_W-1:0]  mv_src;
  logic [IDX_W-1:0]  mv_dst;
  logic [IDX_W-1:0]  rd_p_idx;
  logic [IDX_W-1:0]  rd_q_idx;
  logic              wa_en;
  logic [IDX_W-1:0]  wa_idx;
  logic [DATA_W-1:0] wa_data;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx;
  logic [DATA_W-1:0] wb_data;

  assign rd_idx[PORT_A] = rd_a_idx;
  assign rd_idx[PORT_B] = rd_b_idx;
  assign rd_idx[PORT_P] = rd_p_idx;
  assign rd_idx[PORT_Q] = rd_q_idx;
  assign rd_a_data      = rd_data[PORT_A];
  assign rd_b_data      = rd_data[PORT_B];

  regbank_store #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .NUM_RD (RD_PORTS)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wa_en   (wa_en),
    .wa_idx  (wa_idx),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_idx  (wb_idx),
    .wb_data (wb_data)
  );

  regbank_copy_seq #(
    .IDX_W (IDX_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (copy_start),
    .src    (copy_src),
    .dst    (copy_dst),
    .cnt    (copy_cnt),
    .busy   (busy),
    .mv_src (mv_src),
    .mv_dst (mv_dst)
  );

  regbank_cmd_arb #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_arb (
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .swap_req   (swap_req),
    .swap_x     (swap_x),
    .swap_y     (swap_y),
    .copy_req   (copy_req),
    .mv_src     (mv_src),
    .mv_dst     (mv_dst),
    .data_p     (rd_data[PORT_P]),
    .data_q     (rd_data[PORT_Q]),
    .op         (op),
    .rd_p_idx   (rd_p_idx),
    .rd_q_idx   (rd_q_idx),
    .copy_start (copy_start),
    .wa_en      (wa_en),
    .wa_idx     (wa_idx),
    .wa_data    (wa_data),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data)
  );

  // R12
  move_single_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MOVE) |-> (busy && !wb_en));

  // R3
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wa_en && (wa_idx != '0)) && (rd_a_idx == $past(wa_idx)))
      |-> (rd_a_data == $past(wa_data)));

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

endmodule

// File: tb/tb_regbank_xfer.sv
module tb_regbank_xfer;

  localparam int DW = 64;
  localparam int IW = 8;
  localparam int NR = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [IW-1:0] rd_a_idx = '0;
  logic [DW-1:0] rd_a_data;
  logic [IW-1:0] rd_b_idx = '0;
  logic [DW-1:0] rd_b_data;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic          swap_req = 1'b0;
  logic [IW-1:0] swap_x = '0;
  logic [IW-1:0] swap_y = '0;
  logic          copy_req = 1'b0;
  logic [IW-1:0] copy_src = '0;
  logic [IW-1:0] copy_dst = '0;
  logic [IW-1:0] copy_cnt = '0;
  logic          busy;

  regbank_xfer dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .swap_req(swap_req), .swap_x(swap_x), .swap_y(swap_y),
    .copy_req(copy_req), .copy_src(copy_src), .copy_dst(copy_dst),
    .copy_cnt(copy_cnt), .busy(busy)
  );

  always #4 clk = ~clk;

  logic [DW-1:0] model [NR];
  bit            m_busy;
  logic [IW-1:0] q_dst [$];
  logic [DW-1:0] q_val [$];
  int            n_chk;
  int            n_fail;
  string         cur_req;
  bit            done;

  function automatic logic [DW-1:0] mget(input logic [IW-1:0] i);
    return (i == '0) ? '0 : model[i];
  endfunction

  function automatic logic [DW-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [IW-1:0] d;
    logic [DW-1:0] v;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [IW-1:0] gap;
    bit            down;
    if (m_busy) begin
      d = q_dst.pop_front();
      v = q_val.pop_front();
      if (d != 0) model[d] = v;
      if (q_dst.size() == 0) m_busy = 0;
    end else if (swap_req) begin
      a = mget(swap_x);
      b = mget(swap_y);
      if (swap_x != 0) model[swap_x] = b;
      if (swap_y != 0) model[swap_y] = a;
    end else if (copy_req) begin
      if (copy_cnt != 0) begin
        gap  = copy_dst - copy_src;
        down = (gap != 0) && (gap < copy_cnt);
        for (int k = 0; k < int'(copy_cnt); k++) begin
          int j;
          j = down ? (int'(copy_cnt) - 1 - k) : k;
          q_dst.push_back(IW'(int'(copy_dst) + j));
          q_val.push_back(mget(IW'(int'(copy_src) + j)));
        end
        m_busy = 1;
      end
    end else if (wr_en && (wr_idx != 0)) begin
      model[wr_idx] = wr_data;
    end
  endtask

  // Inputs are set at the falling edge; check, then advance one clock.
  task automatic tick();
    #1;
    chk("busy", {{(DW-1){1'b0}}, busy}, {{(DW-1){1'b0}}, m_busy});
    chk("read A", rd_a_data, mget(rd_a_idx));
    chk("read B", rd_b_data, mget(rd_b_idx));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en    = 1'b0;
    swap_req = 1'b0;
    copy_req = 1'b0;
  endtask

  task automatic sweep();
    for (int k = 0; k < NR / 2; k++) begin
      rd_a_idx = IW'(2 * k);
      rd_b_idx = IW'(2 * k + 1);
      tick();
    end
  endtask

  task automatic do_write(input logic [IW-1:0] i, input logic [DW-1:0] v);
    wr_en = 1'b1; wr_idx = i; wr_data = v;
    rd_a_idx = i; rd_b_idx = IW'($urandom());
    tick();
  endtask

  task automatic do_swap(input logic [IW-1:0] x, input logic [IW-1:0] y);
    swap_req = 1'b1; swap_x = x; swap_y = y;
    rd_a_idx = x; rd_b_idx = y;
    tick();
    tick();
  endtask

  task automatic do_copy(input logic [IW-1:0] s, input logic [IW-1:0] d, input logic [IW-1:0] n);
    copy_req = 1'b1; copy_src = s; copy_dst = d; copy_cnt = n;
    tick();
    while (m_busy) begin
      rd_a_idx = IW'($urandom());
      rd_b_idx = d + IW'($urandom_range(0, (n == 0) ? 0 : n - 1));
      tick();
    end
    tick();
  endtask

  task automatic fill();
    for (int i = 0; i < NR; i++) do_write(IW'(i), rnd64());
  endtask

  initial begin
    cur_req = "R1";
    for (int i = 0; i < NR; i++) model[i] = '0;
    m_busy = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    sweep();

    // R3: plain writes, including index 0
    cur_req = "R3";
    fill();
    do_write(8'd0, 64'hDEAD_BEEF_0000_0001);
    do_write(8'd255, 64'h0123_4567_89AB_CDEF);
    // R2: random reads of present contents
    cur_req = "R2";
    for (int k = 0; k < 64; k++) begin
      rd_a_idx = IW'($urandom()); rd_b_idx = (k % 8 == 0) ? 8'd0 : IW'($urandom());
      tick();
    end

    // R4: swaps of nonzero registers
    cur_req = "R4";
    do_swap(8'd5, 8'd9);
    do_swap(8'd200, 8'd1);
    do_swap(8'd77, 8'd77);
    // R5: swaps with the zero register
    cur_req = "R5";
    do_swap(8'd0, 8'd12);
    do_swap(8'd40, 8'd0);
    do_swap(8'd0, 8'd0);

    // R6: swap beats write and block move; block move beats write
    cur_req = "R6";
    swap_req = 1'b1; swap_x = 8'd20; swap_y = 8'd21;
    wr_en = 1'b1; wr_idx = 8'd22; wr_data = 64'h6666;
    rd_a_idx = 8'd22; rd_b_idx = 8'd20;
    tick(); tick();
    swap_req = 1'b1; swap_x = 8'd30; swap_y = 8'd31;
    copy_req = 1'b1; copy_src = 8'd30; copy_dst = 8'd60; copy_cnt = 8'd5;
    rd_a_idx = 8'd60; rd_b_idx = 8'd31;
    tick(); tick();
    copy_req = 1'b1; copy_src = 8'd70; copy_dst = 8'd90; copy_cnt = 8'd2;
    wr_en = 1'b1; wr_idx = 8'd95; wr_data = 64'h7777;
    rd_a_idx = 8'd95;
    tick();
    while (m_busy) tick();

    // R10: zero-count move, also drops a write on the same cycle
    cur_req = "R10";
    copy_req = 1'b1; copy_src = 8'd3; copy_dst = 8'd100; copy_cnt = 8'd0;
    wr_en = 1'b1; wr_idx = 8'd100; wr_data = 64'hAAAA;
    rd_a_idx = 8'd100;
    tick(); tick();
    sweep();

    // R7 / R8 / R12: disjoint, overlap up, overlap down
    cur_req = "R7";
    do_copy(8'd10, 8'd150, 8'd1);
    do_copy(8'd10, 8'd150, 8'd16);
    cur_req = "R12";
    fill();
    do_copy(8'd40, 8'd43, 8'd20);
    sweep();
    do_copy(8'd80, 8'd70, 8'd25);
    sweep();
    cur_req = "R8";
    fill();
    do_copy(8'd250, 8'd4, 8'd20);
    sweep();
    do_copy(8'd120, 8'd121, 8'd128);
    sweep();
    do_copy(8'd128, 8'd0, 8'd128);
    sweep();

    // R9: zero register as destination and as source
    cur_req = "R9";
    fill();
    do_copy(8'd10, 8'd250, 8'd12);
    sweep();
    do_copy(8'd254, 8'd60, 8'd6);
    sweep();

    // R11: commands pulsed during a running move
    cur_req = "R11";
    fill();
    copy_req = 1'b1; copy_src = 8'd1; copy_dst = 8'd150; copy_cnt = 8'd30;
    tick();
    for (int k = 0; k < 12; k++) begin
      case (k % 3)
        0: begin swap_req = 1'b1; swap_x = 8'd200; swap_y = 8'd201; end
        1: begin wr_en = 1'b1; wr_idx = 8'd202; wr_data = rnd64(); end
        default: begin copy_req = 1'b1; copy_src = 8'd210; copy_dst = 8'd203; copy_cnt = 8'd3; end
      endcase
      rd_a_idx = 8'd200 + IW'(k % 4);
      rd_b_idx = 8'd150 + IW'(k);
      tick();
    end
    while (m_busy) tick();
    sweep();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s watchdog: actual running expected finished", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule